// File: doc/BRIEF.md
# ADC Conversion-Complete Flag Controller

This block keeps the completion status of an eight-result analog-to-digital converter register interface. It has one conversion-complete flag per result register and one sequence-complete flag. A small built-in sequencer produces the result-write strobes. Software talks to the block through a simple bus with read and write strobes: a control register, a recovery-time register, a start register, a status register and eight result registers.

There are two ways to clear a result flag. In the normal policy, software must first read the status register while the flag is set, which arms that channel. A later read of the channel's result register then clears the flag. In the fast policy, any access to a result register clears its flag at once, and the first result read also clears the sequence flag. Writing the start register begins a new sequence, clears the sequence flag and drops every arm.

Clearing the power enable aborts a running sequence. Turning power on starts a recovery countdown, and a start request made during it is held until the countdown ends. With stop-in-wait set, the system wait input freezes the sequencer.

Top module: `adc_flag_ctrl`

## Requirements
- R1: After reset, all conversion flags, the sequence flag, the interrupt and the busy indication are 0, and the control register reads 0.
- R2: A sequencer result write to channel n sets flag n and stores the data, which software can read at result address 8+n. The write to the last channel (7) also sets the sequence flag.
- R3: In normal policy (control bit 1 = 0), a result read clears flag n only if the status register (address 3, bit n = flag n) was read earlier while flag n was 1. A result read with no such status read leaves the flag at 1.
- R4: In fast policy (control bit 1 = 1), any read or write of result address 8+n clears flag n. Any result read clears the sequence flag. Flags never fall without a bus access.
- R5: A write to the start register (address 2) clears the sequence flag and every arm, even when power is off.
- R6: When a result write and a clearing result access hit the same channel in one cycle, the flag ends at 1.
- R7: The interrupt output equals the sequence flag AND the interrupt enable (control bit 3).
- R8: When the power enable (control bit 0) is 0, no result write occurs, a running sequence stops, and a held start request is dropped.
- R9: While stop-in-wait (control bit 2) and the wait input are both 1, no result write occurs and the sequence resumes when wait falls. With stop-in-wait at 0, the sequence runs during wait.
- R10: After the power enable rises, a start request takes effect only after the number of cycles held in the recovery register (address 1).
- R11: The control register (address 0) reads back only its low four bits. The recovery register reads back as written. The status register reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| wait_i | input | 1 | System wait mode indication |
| ccf_o | output | 8 | Per-channel conversion-complete flags |
| scf_o | output | 1 | Sequence-complete flag |
| irq_o | output | 1 | Interrupt request |
| seq_busy_o | output | 1 | Sequencer running |
| res_wr_o | output | 1 | Result-write strobe from the sequencer |
| res_ch_o | output | 3 | Channel of the current result write |

## Verification
A sequencer result write to a channel and a software clearing access to the same channel's result register can land in the same cycle. The bench provokes this by watching the result-write strobe at the falling edge of the clock. When the strobe names channel 4, it drives a fast-policy read of result address 12 in that same cycle. After the edge, flag 4 must still be 1, which shows the set won. A following read must then clear the flag, which shows the read path itself works.

// File: rtl/adc_flag_pkg.sv
package adc_flag_pkg;
   // register addresses in the lower half of the map
   localparam int unsigned A_CTRL  = 0;
   localparam int unsigned A_RCV   = 1;
   localparam int unsigned A_START = 2;
   localparam int unsigned A_STAT  = 3;
   // control bit positions
   localparam int unsigned B_PWR  = 0;
   localparam int unsigned B_FAST = 1;
   localparam int unsigned B_SIW  = 2;
   localparam int unsigned B_IE   = 3;

   typedef struct packed {
      logic ie;
      logic siw;
      logic fast;
      logic pwr;
   } ctrl_t;
endpackage

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
   import adc_flag_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 8,
   parameter int RCV_W      = 8,
   parameter int RCV_RST    = 0,
   parameter bit ALLOW_FAST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output ctrl_t             ctrl_q,
   output logic [RCV_W-1:0]  rcv_q,
   output logic              start_wr,
   output logic              go
);
   logic             ctrl_wr;
   logic             rcv_wr;
   logic             ready;
   logic             pend_q;
   logic             fast_nxt;
   logic [RCV_W-1:0] cnt_q;

   assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
   assign rcv_wr   = bus_wr && (bus_addr == ADDR_W'(A_RCV));
   assign start_wr = bus_wr && (bus_addr == ADDR_W'(A_START));

   generate
      if (ALLOW_FAST) begin : g_fast
         assign fast_nxt = bus_wdata[B_FAST];
      end else begin : g_nofast
         assign fast_nxt = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         rcv_q  <= RCV_W'(RCV_RST);
      end else begin
         if (ctrl_wr) begin
            ctrl_q.pwr  <= bus_wdata[B_PWR];
            ctrl_q.fast <= fast_nxt;
            ctrl_q.siw  <= bus_wdata[B_SIW];
            ctrl_q.ie   <= bus_wdata[B_IE];
         end
         if (rcv_wr) rcv_q <= bus_wdata[RCV_W-1:0];
      end
   end

   // recovery countdown after power-up
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (ctrl_wr && bus_wdata[B_PWR] && !ctrl_q.pwr) begin
         cnt_q <= rcv_q;
      end else if (!ctrl_q.pwr) begin
         cnt_q <= '0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - RCV_W'(1);
      end
   end

   assign ready = ctrl_q.pwr && (cnt_q == '0);

   // held start request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pend_q <= 1'b0;
      else if (!ctrl_q.pwr)  pend_q <= 1'b0;
      else if (start_wr)     pend_q <= 1'b1;
      else if (ready)        pend_q <= 1'b0;
   end

   assign go = pend_q && ready;
endmodule

// File: rtl/adc_stub_seq.sv
module adc_stub_seq #(
   parameter int NUM_CH = 8,
   parameter int STEP   = 4,
   parameter int DATA_W = 8,
   localparam int CH_W  = $clog2(NUM_CH),
   localparam int CNT_W = $clog2(STEP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              pwr,
   input  logic              halt,
   output logic              busy,
   output logic              res_wr,
   output logic [CH_W-1:0]   res_ch,
   output logic              res_last,
   output logic [DATA_W-1:0] res_data
);
   logic [CNT_W-1:0] cnt_q;
   logic             tick;

   assign tick     = busy && pwr && !halt;
   assign res_wr   = tick && (cnt_q == '0);
   assign res_last = res_wr && (res_ch == CH_W'(NUM_CH - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         res_ch   <= '0;
         cnt_q    <= '0;
         res_data <= '0;
      end else if (!pwr) begin
         busy <= 1'b0;
      end else if (go) begin
         busy   <= 1'b1;
         res_ch <= '0;
         cnt_q  <= CNT_W'(STEP - 1);
      end else if (tick) begin
         if (cnt_q == '0) begin
            res_data <= res_data + DATA_W'(1);
            cnt_q    <= CNT_W'(STEP - 1);
            if (res_ch == CH_W'(NUM_CH - 1)) busy <= 1'b0;
            else                             res_ch <= res_ch + CH_W'(1);
         end else begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/adc_ccf_bank.sv
module adc_ccf_bank #(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_vec,
   input  logic [NUM_CH-1:0] sel_vec,
   input  logic              acc_rd,
   input  logic              acc_wr,
   input  logic              stat_rd,
   input  logic              fast,
   input  logic              new_seq,
   input  logic              last_set,
   output logic [NUM_CH-1:0] ccf,
   output logic              scf
);
   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         logic flag_q;
         logic arm_q;
         logic clr;

         assign clr = sel_vec[i] && flag_q &&
                      (fast ? (acc_rd || acc_wr) : (acc_rd && arm_q));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flag_q <= 1'b0;
            else if (set_vec[i]) flag_q <= 1'b1;
            else if (clr)        flag_q <= 1'b0;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    arm_q <= 1'b0;
            else if (new_seq)              arm_q <= 1'b0;
            else if (clr && !set_vec[i])   arm_q <= 1'b0;
            else if (stat_rd && flag_q)    arm_q <= 1'b1;
         end

         assign ccf[i] = flag_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                scf <= 1'b0;
      else if (new_seq)          scf <= 1'b0;
      else if (last_set)         scf <= 1'b1;
      else if (fast && acc_rd)   scf <= 1'b0;
   end
endmodule

// File: rtl/adc_flag_ctrl.sv
module adc_flag_ctrl
   import adc_flag_pkg::*;
#(
   parameter int NUM_CH     = 8,
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 8,
   parameter int RCV_W      = 8,
   parameter int RCV_RST    = 0,
   parameter int STEP       = 4,
   parameter bit ALLOW_FAST = 1'b1,
   localparam int CH_W      = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              wait_i,
   output logic [NUM_CH-1:0] ccf_o,
   output logic              scf_o,
   output logic              irq_o,
   output logic              seq_busy_o,
   output logic              res_wr_o,
   output logic [CH_W-1:0]   res_ch_o
);
   // elaboration checks
   if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
      $error("NUM_CH must be a power of two of at least 2");
   end
   if (ADDR_W < 3 || NUM_CH > (1 << (ADDR_W - 1))) begin : g_bad_addr
      $error("ADDR_W too small for the result window");
   end
   if (DATA_W < NUM_CH || DATA_W < RCV_W || DATA_W < 4) begin : g_bad_data
      $error("DATA_W must hold the status and recovery registers");
   end
   if (STEP < 1) begin : g_bad_step
      $error("STEP must be at least 1");
   end

   ctrl_t             ctrl_q;
   logic [RCV_W-1:0]  rcv_q;
   logic              start_wr;
   logic              go;
   logic              halt;
   logic              res_last;
   logic [DATA_W-1:0] res_data;
   logic              is_res;
   logic [CH_W-1:0]   ridx;
   logic [NUM_CH-1:0] sel_vec;
   logic [NUM_CH-1:0] set_vec;
   logic              stat_rd;
   logic [DATA_W-1:0] res_q [NUM_CH];

   assign halt = ctrl_q.siw && wait_i;

   adc_ctrl_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RCV_W(RCV_W),
      .RCV_RST(RCV_RST), .ALLOW_FAST(ALLOW_FAST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .rcv_q(rcv_q),
      .start_wr(start_wr), .go(go)
   );

   adc_stub_seq #(
      .NUM_CH(NUM_CH), .STEP(STEP), .DATA_W(DATA_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .pwr(ctrl_q.pwr), .halt(halt),
      .busy(seq_busy_o), .res_wr(res_wr_o), .res_ch(res_ch_o),
      .res_last(res_last), .res_data(res_data)
   );

   // address decode
   assign is_res  = bus_addr[ADDR_W-1] && (int'(bus_addr[ADDR_W-2:0]) < NUM_CH);
   assign ridx    = bus_addr[CH_W-1:0];
   assign sel_vec = is_res ? (NUM_CH'(1) << ridx) : '0;
   assign set_vec = res_wr_o ? (NUM_CH'(1) << res_ch_o) : '0;
   assign stat_rd = bus_rd && (bus_addr == ADDR_W'(A_STAT));

   adc_ccf_bank #(.NUM_CH(NUM_CH)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .sel_vec(sel_vec),
      .acc_rd(bus_rd && is_res), .acc_wr(bus_wr && is_res),
      .stat_rd(stat_rd), .fast(ctrl_q.fast), .new_seq(start_wr),
      .last_set(res_last), .ccf(ccf_o), .scf(scf_o)
   );

   // result storage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_CH; k++) res_q[k] <= '0;
      end else if (res_wr_o) begin
         res_q[res_ch_o] <= res_data;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (is_res)                                bus_rdata = res_q[ridx];
      else if (bus_addr == ADDR_W'(A_CTRL))      bus_rdata = DATA_W'(ctrl_q);
      else if (bus_addr == ADDR_W'(A_RCV))       bus_rdata = DATA_W'(rcv_q);
      else if (bus_addr == ADDR_W'(A_STAT))      bus_rdata = DATA_W'(ccf_o);
   end

   assign irq_o = scf_o && ctrl_q.ie;
endmodule

// File: rtl/adc_flag_ctrl_chk.sv
module adc_flag_ctrl_chk
   import adc_flag_pkg::*;
#(
   parameter int NUM_CH  = 8,
   parameter int ADDR_W  = 4,
   localparam int CH_W   = $clog2(NUM_CH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              wait_i,
   input logic [NUM_CH-1:0] ccf_o,
   input logic              scf_o,
   input logic              irq_o,
   input logic              seq_busy_o,
   input logic              res_wr_o,
   input logic [CH_W-1:0]   res_ch_o,
   input logic              pwr_en,
   input logic              siw_en
);
   logic start_now;
   assign start_now = bus_wr && (bus_addr == ADDR_W'(A_START));

   assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_wr_o |=> ccf_o[$past(res_ch_o)]);

   assert_seq_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (res_wr_o && res_ch_o == CH_W'(NUM_CH - 1) && !start_now) |=> scf_o);

   assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_now |=> !scf_o);

   assert_irq_needs_scf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> scf_o);

   assert_no_write_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |-> !res_wr_o);

   assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |=> !seq_busy_o);

   assert_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_i && siw_en) |-> !res_wr_o);

   assert_no_spont_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd || bus_wr) |=> ((ccf_o & $past(ccf_o)) == $past(ccf_o)));
endmodule

bind adc_flag_ctrl adc_flag_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .wait_i(wait_i), .ccf_o(ccf_o), .scf_o(scf_o),
   .irq_o(irq_o), .seq_busy_o(seq_busy_o), .res_wr_o(res_wr_o),
   .res_ch_o(res_ch_o), .pwr_en(ctrl_q.pwr), .siw_en(ctrl_q.siw)
);

// File: tb/adc_flag_ctrl_tb.sv
module adc_flag_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       bus_rd, bus_wr, wait_i;
   logic [3:0] bus_addr;
   logic [7:0] bus_wdata, bus_rdata, ccf_o;
   logic       scf_o, irq_o, seq_busy_o, res_wr_o;
   logic [2:0] res_ch_o;
   int         total = 0;
   int         bad = 0;

   always #4 clk = ~clk;

   adc_flag_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wait_i(wait_i), .ccf_o(ccf_o), .scf_o(scf_o), .irq_o(irq_o),
      .seq_busy_o(seq_busy_o), .res_wr_o(res_wr_o), .res_ch_o(res_ch_o)
   );

   // {write, addr, data, expected readback}
   localparam logic [20:0] VECS [0:7] = '{
      {1'b1, 4'd0, 8'h0A, 8'h00},
      {1'b0, 4'd0, 8'h00, 8'h0A},
      {1'b1, 4'd0, 8'hF4, 8'h00},
      {1'b0, 4'd0, 8'h00, 8'h04},
      {1'b1, 4'd1, 8'h05, 8'h00},
      {1'b0, 4'd1, 8'h00, 8'h05},
      {1'b0, 4'd3, 8'h00, 8'h00},
      {1'b1, 4'd0, 8'h00, 8'h00}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wait_scf();
      int n = 0;
      while (!scf_o && n < 300) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic count_strobes(input int cyc, output int n);
      n = 0;
      repeat (cyc) begin
         @(negedge clk);
         if (res_wr_o) n++;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int n;
      int k;
      bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; wait_i = 0;
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      chk("R1 ccf", ccf_o, 0);
      chk("R1 scf", scf_o, 0);
      chk("R1 irq", irq_o, 0);
      chk("R1 busy", seq_busy_o, 0);

      // R11 register map vectors
      for (int i = 0; i < 8; i++) begin
         if (VECS[i][20]) wr(VECS[i][19:16], VECS[i][15:8]);
         else begin
            rd(VECS[i][19:16], d);
            chk("R11 readback", d, VECS[i][7:0]);
         end
      end

      // R2 / R7 full sequence
      wr(4'd1, 8'd0);
      wr(4'd0, 8'h09);
      wr(4'd2, 8'h00);
      wait_scf();
      chk("R2 all flags", ccf_o, 8'hFF);
      chk("R2 seq flag", scf_o, 1);
      chk("R7 irq on", irq_o, 1);
      wr(4'd0, 8'h01);
      chk("R7 irq masked", irq_o, 0);

      // R3 normal policy
      rd(4'd13, d);
      chk("R2 result data", d, 8'd5);
      chk("R3 no clear without status", ccf_o, 8'hFF);
      rd(4'd3, d);
      chk("R3 status read", d, 8'hFF);
      rd(4'd11, d);
      chk("R3 armed clear", ccf_o, 8'hF7);

      // R5 start clears arms and scf, power off
      wr(4'd0, 8'h00);
      wr(4'd2, 8'h00);
      chk("R5 scf cleared", scf_o, 0);
      rd(4'd8, d);
      chk("R5 arm dropped", ccf_o, 8'hF7);

      // R8 abort
      wr(4'd0, 8'h01);
      wr(4'd2, 8'h00);
      k = 0;
      while (!res_wr_o && k < 100) begin @(negedge clk); k++; end
      wr(4'd0, 8'h00);
      count_strobes(40, n);
      chk("R8 no writes after abort", n, 0);
      chk("R8 busy low", seq_busy_o, 0);
      chk("R8 scf low", scf_o, 0);

      // R8 held start dropped
      wr(4'd1, 8'd30);
      wr(4'd0, 8'h01);
      wr(4'd2, 8'h00);
      wr(4'd0, 8'h00);
      wr(4'd1, 8'd0);
      wr(4'd0, 8'h01);
      count_strobes(40, n);
      chk("R8 pending dropped", n, 0);

      // R10 recovery delay
      wr(4'd0, 8'h00);
      wr(4'd1, 8'd20);
      wr(4'd0, 8'h01);
      wr(4'd2, 8'h00);
      k = 2;
      while (!res_wr_o && k < 100) begin @(negedge clk); k++; end
      chk("R10 delay window", (k >= 20 && k <= 28), 1);
      wait_scf();
      chk("R10 sequence done", scf_o, 1);

      // R4 fast policy
      wr(4'd0, 8'h03);
      rd(4'd10, d);
      chk("R4 fast read clear", ccf_o, 8'hFB);
      chk("R4 scf fast clear", scf_o, 0);
      wr(4'd14, 8'h00);
      chk("R4 fast write clear", ccf_o, 8'hBB);

      // R9 stop in wait
      wr(4'd0, 8'h05);
      wait_i = 1;
      wr(4'd2, 8'h00);
      count_strobes(30, n);
      chk("R9 halted", n, 0);
      chk("R9 busy held", seq_busy_o, 1);
      wait_i = 0;
      wait_scf();
      chk("R9 resumes", scf_o, 1);
      wr(4'd0, 8'h01);
      wait_i = 1;
      wr(4'd2, 8'h00);
      wait_scf();
      chk("R9 runs in wait", scf_o, 1);
      wait_i = 0;

      // R6 collision: set versus fast clear on channel 4
      wr(4'd0, 8'h03);
      wr(4'd2, 8'h00);
      k = 0;
      while (!(res_wr_o && res_ch_o == 3'd4) && k < 200) begin
         @(negedge clk); k++;
      end
      bus_rd = 1'b1; bus_addr = 4'd12;
      @(negedge clk);
      bus_rd = 1'b0;
      chk("R6 set wins", ccf_o[4], 1);
      wait_scf();
      rd(4'd12, d);
      chk("R4 clear after collision", ccf_o[4], 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule